// File: doc/BRIEF.md
# Indexed Timer Control Window

This block puts a small bank of timer control registers behind a two-word window. Software first writes an internal register number into the index word, then reads or writes the data word. The access goes to whichever internal register the stored index selects. A read-modify-write therefore takes four bus accesses: index write, data read, index write again, data write.

There are two internal registers. The global control word holds a run bit and a one-hot prescaler select. Together they drive a tick divider and a shared 64-bit up-counter. The interrupt enable word holds one gate bit per CPU. Each gate bit passes or blocks a compare-match input, which stands in for the per-CPU compare logic, on its way to a registered per-CPU interrupt line.

Two small state machines set the timing. The bus side has states BUS_IDLE and BUS_RESP. A read request moves it from BUS_IDLE to BUS_RESP. The next cycle returns it to BUS_IDLE, unless another read follows, in which case it stays in BUS_RESP. Read data is presented only while in BUS_RESP. The divider has states DIV_HALT and DIV_RUN. A set run bit moves it from DIV_HALT to DIV_RUN. A clear run bit moves it from DIV_RUN back to DIV_HALT. It stays in place otherwise. In DIV_RUN a phase count produces one tick per selected division period.

Top module: `tmr_index_wrap`

## Requirements
- R1: After reset the index word, the control word and the interrupt enable word all read as zero, and `glob_en`, `tick_en`, `count` and `cpu_irq` are zero.
- R2: The index word sits at offset 0x4 and the data window at offset 0x0. The index word holds all 32 written bits and reads back at 0x4. A read returns its data on `rdata` in the cycle after `rd_en` and drives zero otherwise.
- R3: Index 0x00 selects the control word. It stores all 32 bits. Bit 0 is the run bit and appears on `glob_en`.
- R4: Index 0x30 selects the interrupt enable word. It stores all 32 bits, and bit i gates CPU i.
- R5: A data read at any other index returns zero. A data write at any other index changes neither the control word nor the interrupt enable word.
- R6: Control bits 10:8 form a one-hot prescaler select: 001 divides by 1, 010 by 2, 100 by 4.
- R7: A prescaler field of 000, or one with more than one bit set, divides by 1.
- R8: While the run bit is set, `count` advances by exactly one per divided tick. While it is clear, `count` holds its value.
- R9: `cpu_irq[i]` equals `cmp_hit[i]` AND enable bit i, registered one cycle later.
- R10: A read-modify-write done as index write, data read, index write, data write changes only the intended bits of the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | AW (3) | Byte offset: 0x0 data window, 0x4 index word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| cmp_hit | input | NCPU (4) | Per-CPU compare-match inputs |
| cpu_irq | output | NCPU (4) | Gated per-CPU interrupt lines |
| glob_en | output | 1 | Global run bit |
| tick_en | output | 1 | Divided tick enable |
| count | output | CNT_W (64) | Shared free-running counter |

## Verification
The hardest case to reach is a change of division ratio while the divider is already in DIV_RUN with a phase partly used up. The bench reaches it by rewriting only the prescaler field on a running timer through the four-access sequence, without stopping the timer first. It then waits a settling interval and measures the counter advance over a window whose length is a multiple of every ratio. The measurement does not depend on where the phase stood when the field changed. The invalid prescaler codes are driven the same way. Unimplemented indices are written with all ones, and the bench then reads back both real registers to show they did not move.

// File: rtl/tmrw_pkg.sv
package tmrw_pkg;
    typedef enum logic [0:0] {BUS_IDLE, BUS_RESP} bus_st_e;
    typedef enum logic [0:0] {DIV_HALT, DIV_RUN} div_st_e;

    localparam logic [31:0] SEL_CTRL = 32'h0000_0000;
    localparam logic [31:0] SEL_GATE = 32'h0000_0030;
    localparam int RUN_BIT  = 0;
    localparam int PSEL_LSB = 8;
    localparam int PSEL_W   = 3;
    localparam int PH_W     = 2;
endpackage

// File: rtl/tmrw_regs.sv
module tmrw_regs
    import tmrw_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 32,
    parameter logic [AW-1:0] OFS_DATA = 3'h0,
    parameter logic [AW-1:0] OFS_SEL  = 3'h4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl_word,
    output logic [DW-1:0] gate_word
);
    bus_st_e       st_q, st_d;
    logic [DW-1:0] sel_q;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] gate_q;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] rd_mux;
    logic          wr_data;
    logic          wr_sel;

    assign wr_data = wr_en && (addr == OFS_DATA);
    assign wr_sel  = wr_en && (addr == OFS_SEL);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: st_d = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: st_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  st_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_mux = '0;
        if (addr == OFS_SEL) begin
            rd_mux = sel_q;
        end else if (addr == OFS_DATA) begin
            if (sel_q == SEL_CTRL)      rd_mux = ctrl_q;
            else if (sel_q == SEL_GATE) rd_mux = gate_q;
            else                        rd_mux = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            ctrl_q <= '0;
            gate_q <= '0;
            rd_q   <= '0;
        end else begin
            if (wr_sel) sel_q <= wdata;
            if (wr_data && sel_q == SEL_CTRL) ctrl_q <= wdata;
            if (wr_data && sel_q == SEL_GATE) gate_q <= wdata;
            if (rd_en) rd_q <= rd_mux;
        end
    end

    assign rdata     = (st_q == BUS_RESP) ? rd_q : '0;
    assign ctrl_word = ctrl_q;
    assign gate_word = gate_q;

    // R5
    unimpl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && sel_q != SEL_CTRL && sel_q != SEL_GATE)
            |=> ($stable(ctrl_q) && $stable(gate_q)));

    // R2
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == '0));
endmodule

// File: rtl/tmrw_presc.sv
module tmrw_presc
    import tmrw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    div_st_e         st_q, st_d;
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] lim;

    always_comb begin
        unique case (psel)
            3'b001:  lim = PH_W'(0);
            3'b010:  lim = PH_W'(1);
            3'b100:  lim = PH_W'(3);
            default: lim = PH_W'(0);
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DIV_HALT: st_d = run ? DIV_RUN : DIV_HALT;
            DIV_RUN:  st_d = run ? DIV_RUN : DIV_HALT;
            default:  st_d = DIV_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DIV_HALT;
        else        st_q <= st_d;
    end

    assign tick = (st_q == DIV_RUN) && (ph_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (st_q == DIV_RUN) begin
            ph_q <= tick ? '0 : ph_q + 1'b1;
        end else begin
            ph_q <= '0;
        end
    end

    // R6
    back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $past(tick)) |-> (lim == '0));
endmodule

// File: rtl/tmrw_count.sv
module tmrw_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    assign value = cnt_q;

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_index_wrap.sv
module tmr_index_wrap
    import tmrw_pkg::*;
#(
    parameter int AW    = 3,
    parameter int NCPU  = 4,
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NCPU-1:0]  cmp_hit,
    output logic [NCPU-1:0]  cpu_irq,
    output logic             glob_en,
    output logic             tick_en,
    output logic [CNT_W-1:0] count
);
    localparam int DW = 32;

    logic [DW-1:0]   ctrl_word;
    logic [DW-1:0]   gate_word;
    logic [NCPU-1:0] irq_q;

    tmrw_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ctrl_word(ctrl_word), .gate_word(gate_word)
    );

    tmrw_presc u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_word[RUN_BIT]),
        .psel(ctrl_word[PSEL_LSB +: PSEL_W]), .tick(tick_en)
    );

    tmrw_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(tick_en), .value(count)
    );

    generate
        for (genvar i = 0; i < NCPU; i++) begin : g_irq
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) irq_q[i] <= 1'b0;
                else        irq_q[i] <= cmp_hit[i] & gate_word[i];
            end
        end
    endgenerate

    assign cpu_irq = irq_q;
    assign glob_en = ctrl_word[RUN_BIT];

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq != '0) |-> ($past(cmp_hit) != '0));

    // R3
    run_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_en) |-> $past(wr_en));
endmodule

// File: tb/sim_tmr_index_wrap.sv
module sim_tmr_index_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cmp_hit = '0;
    logic [3:0]  cpu_irq;
    logic        glob_en;
    logic        tick_en;
    logic [63:0] count;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_index_wrap u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .cmp_hit(cmp_hit),
        .cpu_irq(cpu_irq), .glob_en(glob_en), .tick_en(tick_en), .count(count)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic reg_wr(input logic [31:0] sel, input logic [31:0] d);
        bus_wr(3'h4, sel);
        bus_wr(3'h0, d);
    endtask

    task automatic reg_rd(input logic [31:0] sel, output logic [31:0] d);
        bus_wr(3'h4, sel);
        bus_rd(3'h0, d);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 glob_en", 64'(glob_en), 0);
        check("R1 tick_en", 64'(tick_en), 0);
        check("R1 count", count, 0);
        check("R1 cpu_irq", 64'(cpu_irq), 0);
        bus_rd(3'h4, v); check("R1 index", 64'(v), 0);
        bus_rd(3'h0, v); check("R1 ctrl", 64'(v), 0);
        reg_rd(32'h30, v); check("R1 gate", 64'(v), 0);
        check("R2 rdata idle", 64'(rdata), 0);
    endtask

    task automatic t_index;
        logic [31:0] v;
        bus_wr(3'h4, 32'hABCD_0030);
        bus_rd(3'h4, v); check("R2 index readback", 64'(v), 64'hABCD_0030);
        bus_rd(3'h0, v); check("R5 full index decode", 64'(v), 0);
        reg_wr(32'h30, 32'h5A5A_0005);
        bus_rd(3'h0, v); check("R4 gate word", 64'(v), 64'h5A5A_0005);
        reg_rd(32'h0, v); check("R3 ctrl untouched", 64'(v), 0);
    endtask

    task automatic t_unimpl;
        logic [31:0] v;
        reg_wr(32'h0, 32'h1234_0200);
        reg_wr(32'h10, 32'hFFFF_FFFF);
        bus_rd(3'h0, v); check("R5 unimpl read", 64'(v), 0);
        reg_wr(32'h31, 32'hFFFF_FFFF);
        reg_rd(32'h0, v); check("R5 ctrl kept", 64'(v), 64'h1234_0200);
        reg_rd(32'h30, v); check("R5 gate kept", 64'(v), 64'h5A5A_0005);
        check("R3 run clear", 64'(glob_en), 0);
        reg_wr(32'h0, 32'h0);
    endtask

    task automatic rate_case(input string req, input logic [2:0] psel, input int div);
        logic [31:0] v;
        logic [63:0] c0;
        reg_rd(32'h0, v);
        v = (v & ~32'h0000_0700) | (32'(psel) << 8) | 32'h1;
        bus_wr(3'h4, 32'h0);
        bus_wr(3'h0, v);
        check({req, " run"}, 64'(glob_en), 1);
        repeat (8) @(negedge clk);
        c0 = count;
        repeat (48) @(negedge clk);
        check(req, count - c0, 64'(48 / div));
    endtask

    task automatic t_stop;
        logic [63:0] c0;
        reg_wr(32'h0, 32'h0000_0400);
        check("R3 run off", 64'(glob_en), 0);
        repeat (4) @(negedge clk);
        c0 = count;
        repeat (24) @(negedge clk);
        check("R8 hold", count, c0);
        check("R8 tick idle", 64'(tick_en), 0);
        reg_wr(32'h0, 32'h0000_0101);
        repeat (3) @(negedge clk);
        check("R8 resume", 64'(count > c0), 1);
    endtask

    task automatic t_irq;
        reg_wr(32'h30, 32'h0000_0005);
        cmp_hit = 4'b1111;
        @(negedge clk);
        check("R9 gated", 64'(cpu_irq), 64'h5);
        cmp_hit = 4'b0010;
        @(negedge clk);
        check("R9 blocked", 64'(cpu_irq), 0);
        reg_wr(32'h30, 32'h0000_000A);
        cmp_hit = 4'b1010;
        @(negedge clk);
        check("R9 new mask", 64'(cpu_irq), 64'hA);
        cmp_hit = 4'b0000;
        @(negedge clk);
        check("R9 clear", 64'(cpu_irq), 0);
    endtask

    task automatic t_rmw;
        logic [31:0] v;
        reg_wr(32'h0, 32'h00C0_0201);
        bus_wr(3'h4, 32'h0);
        bus_rd(3'h0, v);
        bus_wr(3'h4, 32'h0);
        bus_wr(3'h0, (v & ~32'h0000_0700) | 32'h0000_0400);
        reg_rd(32'h0, v); check("R10 rmw ctrl", 64'(v), 64'h00C0_0401);
        reg_rd(32'h30, v); check("R10 gate intact", 64'(v), 64'hA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_index;
        t_unimpl;
        rate_case("R6 div1", 3'b001, 1);
        rate_case("R6 div2", 3'b010, 2);
        rate_case("R6 div4", 3'b100, 4);
        rate_case("R7 code000", 3'b000, 1);
        rate_case("R7 code011", 3'b011, 1);
        rate_case("R7 code111", 3'b111, 1);
        rate_case("R6 div2 again", 3'b010, 2);
        t_stop;
        t_irq;
        t_rmw;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule